// File: doc/BRIEF.md
# Bitfield Move Unit

This block is a purely combinational datapath that copies a contiguous run of bits from a 64-bit source operand into a result word. It supports two placements. In extract placement, a field taken from inside the source is moved down so that it starts at bit 0. In insert placement, a low-order field of the source is moved up to a higher position. The placement follows from a 12-bit control immediate. Its upper six bits give a rotate amount `r` and its lower six bits give a size index `s`.

A single select input chooses how the bits outside the field are filled. With zero fill, every bit outside the field is cleared. With sign fill, the bits above the field repeat the field's top bit, and the bits below the field stay zero. An execution stage can map the three immediate shift operations onto this unit: logical shift left, logical shift right and arithmetic shift right. The upstream decoder only has to supply suitable `r` and `s` values. The block has no clock, so the result follows the inputs within the same cycle.

Top module: `bfm_unit`

## Requirements
- R1: The rotate amount `r` is `imm_i[11:6]` and the size index `s` is `imm_i[5:0]`.
- R2: When `s >= r`, result bits `[s-r:0]` equal source bits `[s:r]`, with source bit `r` landing at result bit 0.
- R3: When `s < r`, result bits `[64-r+s : 64-r]` equal source bits `[s:0]`, with source bit 0 landing at result bit `64-r`.
- R4: With `signed_i = 0`, every result bit outside the moved field is 0.
- R5: With `signed_i = 1`, result bits below the field are 0 and result bits above the field equal source bit `s`, which is the field's most significant bit.
- R6: With `signed_i = 0`, `r = n` and `s = 63`, the result equals the source logically shifted right by `n`.
- R7: With `signed_i = 1`, `r = n` and `s = 63`, the result equals the source arithmetically shifted right by `n`.
- R8: With `signed_i = 0`, `r = (64-n) mod 64` and `s = 63-n`, the result equals the source shifted left by `n`.
- R9: With `r = 0` and `s = 63`, the result equals the source for either value of `signed_i`.
- R10: The result depends only on the present inputs. It holds no state, and all-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source operand |
| imm_i | input | 12 | Control immediate: rotate amount in the upper half, size index in the lower half |
| signed_i | input | 1 | 0 selects zero fill, 1 selects sign fill above the field |
| res_o | output | 64 | Result word |

## Verification
The unit has no registers, so each result is due in the same cycle as the inputs that produce it. The bench changes the inputs just after a rising edge and compares `res_o` at the following falling edge. By then the combinational paths have settled, and no new stimulus has arrived yet.

The bench sweeps every pairing of `r` and `s` in both fill modes over several source patterns. It also runs each shift form for every amount, plus a set of random vectors. Each vector is compared against a bit-by-bit reference model that uses no rotation.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  localparam int unsigned BFM_DEF_W = 64;

  typedef enum logic {
    FILL_ZERO = 1'b0,
    FILL_SIGN = 1'b1
  } fill_kind_e;

  function automatic fill_kind_e fill_from_bit(input logic b);
    return b ? FILL_SIGN : FILL_ZERO;
  endfunction

endpackage

// File: rtl/bfm_rotator.sv
module bfm_rotator #(
  parameter int unsigned W  = bfm_pkg::BFM_DEF_W,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [LW-1:0] amt_i,
  output logic [W-1:0]  data_o
);

  logic [W-1:0] stage [LW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    always_comb begin
      if (amt_i[k]) stage[k+1] = {stage[k][SH-1:0], stage[k][W-1:SH]};
      else          stage[k+1] = stage[k];
    end
  end

  assign data_o = stage[LW];

endmodule

// File: rtl/bfm_mask_gen.sv
module bfm_mask_gen #(
  parameter int unsigned W  = bfm_pkg::BFM_DEF_W,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [LW-1:0] rot_i,
  input  logic [LW-1:0] size_i,
  output logic [W-1:0]  field_mask_o,
  output logic [W-1:0]  top_mask_o,
  output logic [LW-1:0] top_idx_o
);

  logic          extract;
  logic [LW-1:0] lo_idx;
  logic [LW-1:0] hi_idx;

  always_comb begin
    extract = (size_i >= rot_i);
    hi_idx  = size_i - rot_i;
    lo_idx  = extract ? '0 : (LW'(0) - rot_i);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [LW-1:0] IDX = LW'(i);
    always_comb begin
      field_mask_o[i] = (IDX >= lo_idx) && (IDX <= hi_idx);
      top_mask_o[i]   = (IDX > hi_idx);
    end
  end

  assign top_idx_o = hi_idx;

endmodule

// File: rtl/bfm_merge.sv
module bfm_merge #(
  parameter int unsigned W = bfm_pkg::BFM_DEF_W
) (
  input  logic [W-1:0]         rot_i,
  input  logic [W-1:0]         field_mask_i,
  input  logic [W-1:0]         top_mask_i,
  input  bfm_pkg::fill_kind_e  fill_kind_i,
  input  logic                 sign_bit_i,
  output logic [W-1:0]         res_o
);

  logic fill_bit;

  always_comb begin
    fill_bit = (fill_kind_i == bfm_pkg::FILL_SIGN) && sign_bit_i;
    res_o    = (rot_i & field_mask_i) | ({W{fill_bit}} & top_mask_i);
  end

endmodule

// File: rtl/bfm_unit.sv
module bfm_unit (
  input  logic [63:0] src_i,
  input  logic [11:0] imm_i,
  input  logic        signed_i,
  output logic [63:0] res_o
);

  localparam int unsigned W  = 64;
  localparam int unsigned LW = $clog2(W);

  logic [LW-1:0] rot_amt;
  logic [LW-1:0] size_idx;
  logic [W-1:0]  rotated;
  logic [W-1:0]  field_mask;
  logic [W-1:0]  top_mask;
  logic [LW-1:0] top_idx;
  logic          sign_bit;
  bfm_pkg::fill_kind_e fill_kind;

  // R1: immediate split
  assign rot_amt   = imm_i[2*LW-1:LW];
  assign size_idx  = imm_i[LW-1:0];
  assign sign_bit  = src_i[size_idx];
  assign fill_kind = bfm_pkg::fill_from_bit(signed_i);

  bfm_rotator #(.W(W)) u_rot (
    .data_i (src_i),
    .amt_i  (rot_amt),
    .data_o (rotated)
  );

  bfm_mask_gen #(.W(W)) u_mask (
    .rot_i        (rot_amt),
    .size_i       (size_idx),
    .field_mask_o (field_mask),
    .top_mask_o   (top_mask),
    .top_idx_o    (top_idx)
  );

  bfm_merge #(.W(W)) u_merge (
    .rot_i        (rotated),
    .field_mask_i (field_mask),
    .top_mask_i   (top_mask),
    .fill_kind_i  (fill_kind),
    .sign_bit_i   (sign_bit),
    .res_o        (res_o)
  );

  always_comb begin
    assert_field_msb_R2: assert (res_o[top_idx] == src_i[size_idx]);
    assert_zero_below_R5: assert ((res_o & ~(field_mask | top_mask)) == '0);
    assert_masks_disjoint_R3: assert ((field_mask & top_mask) == '0);
    if (!signed_i) begin
      assert_unsigned_clear_R4: assert ((res_o & top_mask) == '0);
    end else begin
      assert_sign_top_R5: assert (res_o[W-1] == src_i[size_idx]);
    end
    if (rot_amt == '0 && size_idx == LW'(W-1)) begin
      assert_pass_through_R9: assert (res_o == src_i);
    end
  end

endmodule

// File: tb/bfm_unit_bench.sv
module bfm_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [63:0] src;
  logic [11:0] imm;
  logic        sgn;
  logic [63:0] res;

  int n_vec  = 0;
  int n_fail = 0;

  bfm_unit u_bfm_unit (
    .src_i    (src),
    .imm_i    (imm),
    .signed_i (sgn),
    .res_o    (res)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] s_in, input int r,
                                        input int s, input logic sg);
    logic [63:0] o;
    int top;
    logic fill;
    o = '0;
    if (s >= r) begin
      for (int i = 0; i <= s - r; i++) o[i] = s_in[r + i];
      top = s - r;
    end else begin
      for (int i = 0; i <= s; i++) o[64 - r + i] = s_in[i];
      top = 64 - r + s;
    end
    fill = sg ? s_in[s] : 1'b0;
    for (int i = top + 1; i < 64; i++) o[i] = fill;
    return o;
  endfunction

  task automatic apply(input logic [63:0] s_in, input int r, input int s,
                       input logic sg, input logic [63:0] exp, input string tag);
    @(posedge clk);
    #1;
    src = s_in;
    imm = {r[5:0], s[5:0]};
    sgn = sg;
    @(negedge clk);
    n_vec++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: src=%h r=%0d s=%0d sgn=%0b got=%h exp=%h",
               tag, s_in, r, s, sg, res, exp);
    end
  endtask

  function automatic string tag_of(input int r, input int s, input logic sg);
    if (r == 0 && s == 63) return "R9";
    if (s >= r) return sg ? "R2/R5" : "R2/R4";
    return sg ? "R3/R5" : "R3/R4";
  endfunction

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'hF0E1_D2C3_B4A5_9687;
    pats[1] = 64'h0123_4567_89AB_CDEF;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h8000_0000_0000_0001;

    rst_n = 1'b0;
    src = '0;
    imm = '0;
    sgn = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: all-zero inputs give zero, result same cycle
    apply(64'h0, 0, 0, 1'b0, 64'h0, "R10");
    apply(64'h0, 0, 0, 1'b1, 64'h0, "R10");

    // R1: immediate split - r from high half, s from low half
    apply(64'h0000_0000_0000_FF00, 8, 15, 1'b0, 64'hFF, "R1");
    apply(64'h0000_0000_0000_FF00, 15, 8, 1'b0,
          model(64'h0000_0000_0000_FF00, 15, 8, 1'b0), "R1");

    // R9: pass-through
    apply(pats[0], 0, 63, 1'b0, pats[0], "R9");
    apply(pats[0], 0, 63, 1'b1, pats[0], "R9");

    // R5: sign fill directed
    apply(64'h0000_0000_0000_0080, 0, 7, 1'b1, 64'hFFFF_FFFF_FFFF_FF80, "R5");
    apply(64'h0000_0000_0000_0080, 0, 7, 1'b0, 64'h0000_0000_0000_0080, "R4");
    // R3: insert with sign fill
    apply(64'h0000_0000_0000_0009, 60, 3, 1'b1, 64'hFFFF_FFFF_FFFF_FF90, "R3");

    // R6, R7, R8: shift forms, every amount
    for (int n = 0; n < 64; n++) begin
      apply(pats[0], n, 63, 1'b0, pats[0] >> n, "R6");
      apply(pats[0], n, 63, 1'b1, 64'($signed(pats[0]) >>> n), "R7");
      apply(pats[1], (64 - n) % 64, 63 - n, 1'b0, pats[1] << n, "R8");
    end

    // R2, R3, R4, R5: full sweep of r and s
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 64; r++)
        for (int s = 0; s < 64; s++)
          for (int g = 0; g < 2; g++)
            apply(pats[p], r, s, g[0], model(pats[p], r, s, g[0]), tag_of(r, s, g[0]));

    // random operands
    for (int k = 0; k < 500; k++) begin
      logic [63:0] rs;
      int rr, ss;
      logic gg;
      rs = {$urandom(), $urandom()};
      rr = int'($urandom_range(63, 0));
      ss = int'($urandom_range(63, 0));
      gg = 1'($urandom_range(1, 0));
      apply(rs, rr, ss, gg, model(rs, rr, ss, gg), tag_of(rr, ss, gg));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, got=timeout exp=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule